// File: doc/BRIEF.md
# Bit-Sampled Serial EEPROM Target

This block models a 256-byte two-wire serial EEPROM as seen from a host that can only sample the bus by software. A register interface writes the clock and data levels one at a time. Each write is marked by a one-cycle update strobe. The block decides what each new pair of levels means by comparing it with the previous pair. The result is one of four events: a start condition, a stop condition, a clock rising edge, or nothing.

A single tick counter, advanced on qualified rising edges, splits a transaction into phases. The first eight bits after a start form a control byte, and its lowest bit selects read or write. In a write, the next eight bits form the word address. In a read, the block shifts the data register out MSB first on its data output. The data register is refilled from storage whenever an address byte or a read byte completes, and successive reads walk through the array.

The storage is not written by the bus. At reset it loads a computed image, where byte `a` holds `(a*29 + 90) mod 256`. The data output idles high, as a released line does. A one-cycle error flag reports a data change that coincides with a clock rising edge.

Top module: `i2c_bit_eeprom`

## Requirements
- R1: After reset, `sda_out` is 1 and `proto_err` is 0. Byte `a` of storage holds `(a*29+90) mod 256`. The word address and data register are both 0, so a read issued before any address write returns 0x00 first, then storage byte 1.
- R2: An update with SCL high in both the previous and the new sample, where SDA falls, is a start. The next eight qualified edges are then taken as a control byte. A matching update where SDA rises is a stop: it ends any transfer, releases `sda_out` to 1, and returns the block to idle.
- R3: In idle (no start since the last stop or finished write), rising edges are ignored. `sda_out` stays 1, no acknowledge is given, and `proto_err` stays 0.
- R4: A qualified edge is an update that takes SCL from low to high while SDA equals its previous sample. The control byte is taken from eight qualified edges, MSB first. After the eighth edge `sda_out` is 0 (acknowledge), and it returns to 1 on the next rising edge.
- R5: When control bit 0 is 0 (write), the next eight qualified edges form the word address, MSB first. After the eighth edge `sda_out` is 0 for one clock. After that the block is idle until the next start.
- R6: When control bit 0 is 1 (read), each of the eight rising edges after the acknowledge clock puts the next data-register bit on `sda_out`, MSB first. Each bit holds until the following rising edge.
- R7: Completing an address byte loads the data register from storage at that address. A restart followed by a read therefore returns the byte at the written address.
- R8: Completing a read byte increments the address modulo 256 and reloads the data register. The next rising edge (the host's acknowledge clock) drives `sda_out` to 1, and the eight edges after it return the following byte. Address 0xFF is followed by 0x00.
- R9: An update that takes SCL from low to high while SDA differs from its previous sample, outside idle and outside an acknowledge clock, sets `proto_err` to 1 for one clock. The bit is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd | input | 1 | Strobe: a new bus sample is present this cycle |
| scl_in | input | 1 | Sampled clock level |
| sda_in | input | 1 | Sampled data level driven by the host |
| sda_out | output | 1 | Data level driven by the target; 1 means released |
| proto_err | output | 1 | One-cycle flag for a data change during a clock rising edge |

## Verification
A tick counter off by one moves the acknowledge to the wrong bit. That shows on `sda_out` within the same control or address byte, at the ninth or seventh edge instead of the eighth. A wrong address or data register shows on the first byte shifted out after a restart. A wrong increment shows on the second byte of a sequential read, and the 0xFF to 0x00 case exposes a wrap fault. A stale acknowledge or a missed idle state shows as a low `sda_out` on the next ignored clock.

// File: rtl/eep_pkg.sv
// Package: shared event type and the reset-time image formula.
// Assumes storage widths never exceed 32 bits.
package eep_pkg;

    parameter int unsigned IMG_MUL = 29;
    parameter int unsigned IMG_ADD = 90;

    // Bus event decoded from one sample pair
    typedef enum logic [1:0] {
        BUS_NONE  = 2'd0,
        BUS_START = 2'd1,
        BUS_STOP  = 2'd2,
        BUS_RISE  = 2'd3
    } bus_ev_e;

    // Initial contents of storage byte a (caller truncates to its width)
    function automatic int unsigned image_byte(input int unsigned a);
        return a * IMG_MUL + IMG_ADD;
    endfunction

endpackage

// File: rtl/eep_bus_sampler.sv
// Bus sampler: holds the previous SCL/SDA sample and classifies each new
// sample as start, stop, rising edge or nothing.
// Assumes the bus is idle (both lines high) out of reset.
module eep_bus_sampler
    import eep_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    upd,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_e ev,
    output logic    sda_same
);

    logic scl_q;
    logic sda_q;

    // Keep the last sample so that edges and conditions can be seen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else if (upd) begin
            scl_q <= scl_in;
            sda_q <= sda_in;
        end
    end

    // Classify the new sample against the held one
    always_comb begin
        sda_same = (sda_in == sda_q);
        if (scl_q && scl_in && !sda_same) begin
            ev = sda_in ? BUS_STOP : BUS_START;
        end else if (!scl_q && scl_in) begin
            ev = BUS_RISE;
        end else begin
            ev = BUS_NONE;
        end
    end

endmodule

// File: rtl/eep_store.sv
// Storage: DEPTH bytes loaded from the computed image on reset, with an
// asynchronous read port. The bus never writes this array.
module eep_store
    import eep_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Load the image into every cell while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int unsigned i = 0; i < DEPTH; i++) begin
                cells[i] <= DATA_W'(image_byte(i));
            end
        end
    end

    // Combinational read of the selected cell
    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/eep_phase_seq.sv
// Phase sequencer: tick counter, control/address/data registers and the
// target's data drive. Tick 1..DATA_W collects the control byte, and
// DATA_W+1..2*DATA_W carries the address or read byte.
// Assumes ADDR_W <= DATA_W and events qualified by upd.
module eep_phase_seq
    import eep_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  bus_ev_e           ev,
    input  logic              sda_same,
    input  logic              sda_bit,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              sda_out,
    output logic              proto_err
);

    localparam int unsigned TICK_LAST = 2 * DATA_W;
    localparam int unsigned TICK_W    = $clog2(TICK_LAST + 2);
    localparam logic [TICK_W-1:0] T_FIRST = TICK_W'(1);
    localparam logic [TICK_W-1:0] T_CTL   = TICK_W'(DATA_W);
    localparam logic [TICK_W-1:0] T_BYTE0 = TICK_W'(DATA_W + 1);
    localparam logic [TICK_W-1:0] T_END   = TICK_W'(TICK_LAST);

    logic [TICK_W-1:0] tick;
    logic              ack_pend;
    logic [DATA_W-1:0] ctrl;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] dreg;
    logic              drv;
    logic              err;

    logic              idle;
    logic              is_read;
    logic              in_ctl;
    logic              last_ctl;
    logic              last_byte;
    logic [ADDR_W-1:0] addr_shift;
    logic [ADDR_W-1:0] addr_inc;

    // Phase decode from the tick counter
    always_comb begin
        idle       = (tick == '0) && !ack_pend;
        is_read    = ctrl[0];
        in_ctl     = (tick != '0) && (tick <= T_CTL);
        last_ctl   = (tick == T_CTL);
        last_byte  = (tick == T_END);
        addr_shift = {addr[ADDR_W-2:0], sda_bit};
        addr_inc   = addr + ADDR_W'(1);
        rd_addr    = is_read ? addr_inc : addr_shift;
    end

    // Advance the transaction on each qualified bus event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick     <= '0;
            ack_pend <= 1'b0;
            ctrl     <= '0;
            addr     <= '0;
            dreg     <= '0;
            drv      <= 1'b1;
            err      <= 1'b0;
        end else begin
            err <= 1'b0;
            if (upd) begin
                case (ev)
                    BUS_START: begin
                        tick     <= T_FIRST;
                        ctrl     <= '0;
                        ack_pend <= 1'b0;
                        drv      <= 1'b1;
                    end
                    BUS_STOP: begin
                        tick     <= '0;
                        ack_pend <= 1'b0;
                        drv      <= 1'b1;
                    end
                    BUS_RISE: begin
                        if (!idle) begin
                            if (ack_pend) begin
                                ack_pend <= 1'b0;
                                drv      <= 1'b1;
                            end else if (!sda_same) begin
                                err <= 1'b1;
                            end else if (in_ctl) begin
                                ctrl <= {ctrl[DATA_W-2:0], sda_bit};
                                tick <= tick + TICK_W'(1);
                                if (last_ctl) begin
                                    ack_pend <= 1'b1;
                                    drv      <= 1'b0;
                                end
                            end else begin
                                if (is_read) begin
                                    drv  <= dreg[DATA_W-1];
                                    dreg <= {dreg[DATA_W-2:0], 1'b0};
                                end else begin
                                    addr <= addr_shift;
                                end
                                if (last_byte) begin
                                    ack_pend <= 1'b1;
                                    dreg     <= rd_data;
                                    if (is_read) begin
                                        addr <= addr_inc;
                                        tick <= T_BYTE0;
                                    end else begin
                                        drv  <= 1'b0;
                                        tick <= '0;
                                    end
                                end else begin
                                    tick <= tick + TICK_W'(1);
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_out   = drv;
    assign proto_err = err;

    // Tick never passes the last bit of the second byte
    assert_tick_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick <= T_END);

    // Idle target keeps the line released
    assert_idle_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> sda_out);

    // A start always restarts the count at the first control bit
    assert_start_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && ev == BUS_START) |=> (tick == T_FIRST) && !ack_pend);

    // A stop always releases the line and idles
    assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && ev == BUS_STOP) |=> sda_out && idle);

    // Address moves only on a bus update
    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(addr));

    // An error flag only follows a rising-edge update
    assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> ($past(upd) && $past(ev) == BUS_RISE));

endmodule

// File: rtl/i2c_bit_eeprom.sv
// Top: bit-sampled serial EEPROM target. The host presents SCL/SDA levels
// with a strobe; the target answers on sda_out (1 = released).
// Assumes one sample per strobe and a synchronous active-low reset.
module i2c_bit_eeprom
    import eep_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_out,
    output logic proto_err
);

    bus_ev_e           ev;
    logic              sda_same;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    eep_bus_sampler u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (upd),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .ev       (ev),
        .sda_same (sda_same)
    );

    eep_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    eep_phase_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (upd),
        .ev        (ev),
        .sda_same  (sda_same),
        .sda_bit   (sda_in),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .sda_out   (sda_out),
        .proto_err (proto_err)
    );

endmodule

// File: tb/sim_i2c_bit_eeprom.sv
// Directed bench: each task drives one scenario and checks its own results.
module sim_i2c_bit_eeprom;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd = 1'b0;
    logic scl_i = 1'b1;
    logic sda_i = 1'b1;
    logic sda_o;
    logic perr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    i2c_bit_eeprom u0 (
        .clk (clk), .rst_n (rst_n), .upd (upd),
        .scl_in (scl_i), .sda_in (sda_i),
        .sda_out (sda_o), .proto_err (perr)
    );

    function automatic logic [7:0] img(input int a);
        return 8'((a % 256) * 29 + 90);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One bus sample; outputs are valid on return
    task automatic bus(input logic s, input logic d);
        scl_i = s; sda_i = d; upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
    endtask

    // One clock bit; o is sda_out right after the rising edge
    task automatic send_bit(input logic b, output logic o);
        bus(1'b0, b);
        bus(1'b1, b);
        o = sda_o;
        bus(1'b0, b);
    endtask

    task automatic do_start();
        bus(1'b0, 1'b1);
        bus(1'b1, 1'b1);
        bus(1'b1, 1'b0);
        bus(1'b0, 1'b0);
    endtask

    task automatic do_stop();
        bus(1'b0, 1'b0);
        bus(1'b1, 1'b0);
        bus(1'b1, 1'b1);
    endtask

    // Eight bits MSB first; ack is sda_out after the eighth edge
    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic o;
        for (int i = 7; i >= 0; i--) send_bit(v[i], o);
        ack = o;
    endtask

    task automatic read_byte(output logic [7:0] v);
        logic o;
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b1, o);
            v[i] = o;
        end
    endtask

    // Control write, address byte, ack clock; leaves the target idle
    task automatic set_addr(input logic [7:0] a);
        logic k;
        do_start();
        send_byte(8'hA0, k);
        check(k == 1'b0, "R4 control ack", k, 0);
        send_bit(1'b1, k);
        check(k == 1'b1, "R4 ack released", k, 1);
        send_byte(a, k);
        check(k == 1'b0, "R5 address ack", k, 0);
        send_bit(1'b1, k);
        check(k == 1'b1, "R5 address ack one clock", k, 1);
    endtask

    task automatic open_read();
        logic k;
        do_start();
        send_byte(8'hA1, k);
        check(k == 1'b0, "R4 read control ack", k, 0);
        send_bit(1'b1, k);
        check(k == 1'b1, "R6 ack clock released", k, 1);
    endtask

    task automatic t_reset();
        check(sda_o == 1'b1, "R1 sda_out reset", sda_o, 1);
        check(perr == 1'b0, "R1 proto_err reset", perr, 0);
    endtask

    // Read before any address write: data 0x00, then byte 1
    task automatic t_reset_read();
        logic [7:0] v;
        logic k;
        open_read();
        read_byte(v);
        check(v == 8'h00, "R1 first read after reset", v, 0);
        send_bit(1'b0, k);
        check(k == 1'b1, "R8 host ack clock releases", k, 1);
        read_byte(v);
        check(v == img(1), "R1 byte 1 after reset read", v, img(1));
        send_bit(1'b1, k);
        do_stop();
        check(sda_o == 1'b1, "R2 stop releases", sda_o, 1);
    endtask

    task automatic t_idle();
        logic k;
        bit all_hi = 1;
        for (int i = 0; i < 10; i++) begin
            send_bit(logic'(i % 2), k);
            if (k !== 1'b1 || perr !== 1'b0) all_hi = 0;
        end
        check(all_hi, "R3 idle clocks ignored", all_hi, 1);
    endtask

    task automatic t_random_read(input logic [7:0] a);
        logic [7:0] v;
        logic k;
        set_addr(a);
        send_bit(1'b0, k);
        check(k == 1'b1, "R5 idle after address", k, 1);
        open_read();
        read_byte(v);
        check(v == img(a), "R7 random read data", v, img(a));
        check(perr == 1'b0, "R9 no error in clean traffic", perr, 0);
        send_bit(1'b1, k);
        do_stop();
    endtask

    task automatic t_seq_read(input logic [7:0] a, input int n);
        logic [7:0] v;
        logic k;
        set_addr(a);
        open_read();
        for (int j = 0; j < n; j++) begin
            read_byte(v);
            check(v == img(a + j), "R8 sequential byte", v, img(a + j));
            send_bit(j == n - 1, k);
            check(k == 1'b1, "R8 host ack clock releases", k, 1);
        end
        do_stop();
    endtask

    // Stop after four control bits aborts the transfer
    task automatic t_stop_abort();
        logic k;
        bit all_hi = 1;
        do_start();
        for (int i = 0; i < 4; i++) send_bit(1'b1, k);
        do_stop();
        for (int i = 0; i < 9; i++) begin
            send_bit(1'b0, k);
            if (k !== 1'b1) all_hi = 0;
        end
        check(all_hi, "R2 stop aborts control byte", all_hi, 1);
    endtask

    task automatic t_proto_err();
        logic k;
        do_start();
        bus(1'b0, 1'b1);
        bus(1'b1, 1'b0);
        check(perr == 1'b1, "R9 error flagged", perr, 1);
        bus(1'b1, 1'b0);
        check(perr == 1'b0, "R9 error one clock", perr, 0);
        bus(1'b0, 1'b0);
        send_byte(8'hA0, k);
        check(k == 1'b0, "R9 bad bit not counted", k, 0);
        send_bit(1'b1, k);
        do_stop();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reset_read();
        t_idle();
        t_random_read(8'h3C);
        t_random_read(8'hA5);
        t_seq_read(8'h10, 3);
        t_seq_read(8'hFE, 3);
        t_stop_abort();
        t_proto_err();
        t_random_read(8'h00);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule